// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Replay

This block is a first-in first-out buffer that links a producer clocked by `wclk` with a consumer clocked by `rclk`. Words are `DATA_W` bits wide, and the storage array holds 2^`ADDR_W` entries. The read timing behaviour is fixed while master reset is held.

In standard timing, the consumer reads the empty indication and pulses `rd_en`. Each accepted read moves the oldest word into the output register. In look-ahead timing, the oldest word is placed on `dout` without any request, and `rd_en` acknowledges it. In both timings the same output, `rstat`, tells the consumer that nothing can be taken. The block also reports:
- `wstat`, the full indication, in the write domain.
- `half_full` and `almost_full`, in the write domain.
- `almost_empty`, in the read domain.

The two offsets behind the almost flags can be programmed. A partial reset empties the buffer but keeps the timing choice and the offsets. A replay request rewinds reading to the first storage location, so that the words written since the last reset can be read a second time.

Top module: `dual_mode_fifo`

## Requirements
- R1: After master reset the flags are:
  - `rstat`=1 and `almost_empty`=1.
  - `wstat`=0, `half_full`=0 and `almost_full`=0.
  - `dout`=0.
- R2: The level of `fwft_sel` is captured while `mrst_n` is low (0 selects standard timing, 1 selects look-ahead timing). Later changes of `fwft_sel` and partial resets leave that choice unchanged.
- R3: Standard timing works as follows:
  - `rstat` is 1 exactly when no word is stored.
  - A rising `rclk` with `rd_en`=1 and `rstat`=0 loads the oldest word into `dout`.
  - Without such a read, `dout` holds its value, including after writes.
- R4: Look-ahead timing works as follows:
  - `rstat` is 0 exactly when `dout` holds a valid word.
  - The oldest word appears on `dout` with no request.
  - `rd_en`=1 at a rising `rclk` consumes that word and shows the next one.
  - With `rd_en`=0, `dout` and `rstat` hold.
- R5: `wstat` is 1 when 2^`ADDR_W` words wait in the storage array. A write presented while `wstat`=1 is dropped.
- R6: A read request while `rstat`=1 leaves `dout` unchanged.
- R7: `half_full` is 1 when the storage array holds 2^`ADDR_W`/2+1 or more words.
- R8: `almost_empty` is 1 when the count of readable words is no greater than the empty offset. In look-ahead timing, the word on `dout` is included in that count.
- R9: `almost_full` is 1 when the storage array holds at least 2^`ADDR_W` minus the full offset words. In look-ahead timing, the word already on `dout` is not counted.
- R10: A write-clock edge with `ofs_wr`=1 loads `ae_ofs_in` and `af_ofs_in` as the two offsets. Master reset restores `AE_DEFAULT` and `AF_DEFAULT`. Partial reset keeps the loaded values.
- R11: Partial reset (`prst_n`=0) discards all stored words and returns every flag to its R1 state.
- R12: A rising `rclk` with `rt`=1 moves the read position back to storage location 0 and sets `rstat` to 1 for the setup. Reads afterwards return the words again, starting from the first word written since the last reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| fwft_sel | input | 1 | Read timing choice, captured during master reset |
| wr_en | input | 1 | Write request |
| din | input | DATA_W | Write data |
| ofs_wr | input | 1 | Load strobe for both offsets (write clock) |
| ae_ofs_in | input | ADDR_W | Almost-empty offset value |
| af_ofs_in | input | ADDR_W | Almost-full offset value |
| rd_en | input | 1 | Read request or acknowledge |
| rt | input | 1 | Replay request (read clock) |
| dout | output | DATA_W | Output register |
| rstat | output | 1 | Nothing can be read (empty, or not ready) |
| wstat | output | 1 | Storage full |
| half_full | output | 1 | More than half occupied |
| almost_empty | output | 1 | At or below the empty offset |
| almost_full | output | 1 | Within the full offset of full |

## Verification
The bench uses the default `ADDR_W`=4 and `DATA_W`=36, which gives a 16-entry array. With this size the full, half-full (9 words) and almost-full boundaries are reached with short bursts, and every fill and drain is checked word by word. `AE_DEFAULT`=1 and `AF_DEFAULT`=1 differ from the loaded offsets of 3. This lets a single stored-word count tell programmed offsets from restored defaults after a partial reset and after a master reset. Both timings are exercised with replay, including a replay made after the buffer has been drained completely.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dmf_rst_sync.sv
// Asynchronous assertion, release aligned to clk through two flops.
module dmf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_n  <= meta_q;
    end
  end
endmodule

// File: rtl/dmf_gray_sync.sv
// Two-stage synchronizer for a Gray-coded pointer.
module dmf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/dmf_wr_ctl.sv
// Write pointer, write-side flags and the offset registers.
module dmf_wr_ctl #(
  parameter int AW     = 4,
  parameter int AE_DEF = 1,
  parameter int AF_DEF = 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          wr_en,
  input  logic          ofs_wr,
  input  logic [AW-1:0] ae_ofs_in,
  input  logic [AW-1:0] af_ofs_in,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_go,
  output logic          wstat,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] ae_ofs
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] HALF_V  = (DEPTH_V >> 1) + {{AW{1'b0}}, 1'b1};

  logic [AW:0]   wbin_q, wbin_d, rbin_s, cnt_d, af_lim;
  logic [AW-1:0] af_ofs_q;
  logic          full_d, hf_d, af_d;

  // Gray to binary for the synchronized read pointer
  always_comb begin
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end
  end

  assign wr_go = wr_en & ~wstat;
  assign waddr = wbin_q[AW-1:0];

  always_comb begin
    wbin_d = wbin_q + {{AW{1'b0}}, wr_go};
    cnt_d  = wbin_d - rbin_s;
    af_lim = DEPTH_V - {1'b0, af_ofs_q};
    full_d = (cnt_d >= DEPTH_V);
    hf_d   = (cnt_d >= HALF_V);
    af_d   = (cnt_d >= af_lim);
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q      <= '0;
      wgray       <= '0;
      wstat       <= 1'b0;
      half_full   <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin_q      <= wbin_d;
      wgray       <= wbin_d ^ (wbin_d >> 1);
      wstat       <= full_d;
      half_full   <= hf_d;
      almost_full <= af_d;
    end
  end

  // Offsets survive partial reset; only master reset restores them
  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      ae_ofs   <= AE_DEF[AW-1:0];
      af_ofs_q <= AF_DEF[AW-1:0];
    end else if (ofs_wr) begin
      ae_ofs   <= ae_ofs_in;
      af_ofs_q <= af_ofs_in;
    end
  end
endmodule

// File: rtl/dmf_rd_ctl.sv
// Read pointer, output register, timing mode and replay setup.
module dmf_rd_ctl
  import dmf_pkg::*;
#(
  parameter int AW = 4,
  parameter int W  = 36
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mrst_n,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic          rt,
  input  logic [AW:0]   wgray_s,
  input  logic [W-1:0]  rdata,
  input  logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  dout,
  output logic          rstat,
  output logic          almost_empty
);
  rd_mode_e      mode_q;
  logic [AW:0]   rbin_q, rbin_d, wbin_s, cnt_d;
  logic [W-1:0]  dout_d;
  logic          valid_q, valid_d, busy_q, busy_d;
  logic          has_word, look_ahead, stat_d, ae_d;

  always_comb begin
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) begin
      wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end
  end

  assign raddr      = rbin_q[AW-1:0];
  assign has_word   = (wbin_s != rbin_q);
  assign look_ahead = (mode_q == MODE_FWFT);

  // Timing choice is sampled on every edge while master reset is held
  always_ff @(posedge rclk) begin
    if (!mrst_n) begin
      mode_q <= rd_mode_e'(fwft_sel);
    end
  end

  always_comb begin
    rbin_d  = rbin_q;
    valid_d = valid_q;
    busy_d  = 1'b0;
    dout_d  = dout;
    if (rt) begin
      rbin_d  = '0;
      valid_d = 1'b0;
      busy_d  = 1'b1;
    end else if (!busy_q) begin
      if (!look_ahead) begin
        if (rd_en && !rstat) begin
          dout_d = rdata;
          rbin_d = rbin_q + {{AW{1'b0}}, 1'b1};
        end
      end else begin
        if ((!valid_q || rd_en) && has_word) begin
          dout_d  = rdata;
          rbin_d  = rbin_q + {{AW{1'b0}}, 1'b1};
          valid_d = 1'b1;
        end else if (rd_en) begin
          valid_d = 1'b0;
        end
      end
    end
    cnt_d  = wbin_s - rbin_d + {{AW{1'b0}}, look_ahead & valid_d};
    stat_d = busy_d | (look_ahead ? ~valid_d : (wbin_s == rbin_d));
    ae_d   = (cnt_d <= {1'b0, ae_ofs});
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q       <= '0;
      rgray        <= '0;
      valid_q      <= 1'b0;
      busy_q       <= 1'b0;
      dout         <= '0;
      rstat        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin_q       <= rbin_d;
      rgray        <= rbin_d ^ (rbin_d >> 1);
      valid_q      <= valid_d;
      busy_q       <= busy_d;
      dout         <= dout_d;
      rstat        <= stat_d;
      almost_empty <= ae_d;
    end
  end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 36,
  parameter int AE_DEFAULT = 1,
  parameter int AF_DEFAULT = 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  input  logic              ofs_wr,
  input  logic [ADDR_W-1:0] ae_ofs_in,
  input  logic [ADDR_W-1:0] af_ofs_in,
  input  logic              rd_en,
  input  logic              rt,
  output logic [DATA_W-1:0] dout,
  output logic              rstat,
  output logic              wstat,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              any_rst_n;
  logic              w_mrst_n, w_rst_n, r_mrst_n, r_rst_n;
  logic [ADDR_W:0]   w_gray, w_gray_s, r_gray, r_gray_s;
  logic [ADDR_W-1:0] waddr, raddr, ae_ofs;
  logic              wr_go;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] mem [DEPTH];

  assign any_rst_n = mrst_n & prst_n;

  dmf_rst_sync u_wm (.clk(wclk), .arst_n(mrst_n),    .rst_n(w_mrst_n));
  dmf_rst_sync u_wa (.clk(wclk), .arst_n(any_rst_n), .rst_n(w_rst_n));
  dmf_rst_sync u_rm (.clk(rclk), .arst_n(mrst_n),    .rst_n(r_mrst_n));
  dmf_rst_sync u_ra (.clk(rclk), .arst_n(any_rst_n), .rst_n(r_rst_n));

  dmf_gray_sync #(.W(ADDR_W + 1)) u_w2r (
    .clk(rclk), .rst_n(r_rst_n), .d(w_gray), .q(w_gray_s));
  dmf_gray_sync #(.W(ADDR_W + 1)) u_r2w (
    .clk(wclk), .rst_n(w_rst_n), .d(r_gray), .q(r_gray_s));

  dmf_wr_ctl #(.AW(ADDR_W), .AE_DEF(AE_DEFAULT), .AF_DEF(AF_DEFAULT)) u_wr (
    .wclk(wclk), .rst_n(w_rst_n), .mrst_n(w_mrst_n), .wr_en(wr_en),
    .ofs_wr(ofs_wr), .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in),
    .rgray_s(r_gray_s), .wgray(w_gray), .waddr(waddr), .wr_go(wr_go),
    .wstat(wstat), .half_full(half_full), .almost_full(almost_full),
    .ae_ofs(ae_ofs));

  dmf_rd_ctl #(.AW(ADDR_W), .W(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(r_rst_n), .mrst_n(r_mrst_n), .fwft_sel(fwft_sel),
    .rd_en(rd_en), .rt(rt), .wgray_s(w_gray_s), .rdata(rdata),
    .ae_ofs(ae_ofs), .raddr(raddr), .rgray(r_gray), .dout(dout),
    .rstat(rstat), .almost_empty(almost_empty));

  // Storage array: synchronous write, combinational read into the output register
  always_ff @(posedge wclk) begin
    if (wr_go) begin
      mem[waddr] <= din;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 36
) (
  input logic              wclk,
  input logic              rclk,
  input logic              w_rst_n,
  input logic              r_rst_n,
  input logic              wr_en,
  input logic [ADDR_W:0]   w_gray,
  input logic              wstat,
  input logic              half_full,
  input logic              almost_full,
  input logic              rd_en,
  input logic              rt,
  input logic              rstat,
  input logic [DATA_W-1:0] dout
);
  assert_full_write_dropped_R5: assert property (
    @(posedge wclk) disable iff (!w_rst_n) (wstat && wr_en) |=> $stable(w_gray));

  assert_full_implies_half_R7: assert property (
    @(posedge wclk) disable iff (!w_rst_n) wstat |-> half_full);

  assert_full_implies_almost_R9: assert property (
    @(posedge wclk) disable iff (!w_rst_n) wstat |-> almost_full);

  assert_idle_output_hold_R4: assert property (
    @(posedge rclk) disable iff (!r_rst_n)
    (!rstat && !rd_en && !rt) |=> (!rstat && $stable(dout)));

  assert_replay_not_ready_R12: assert property (
    @(posedge rclk) disable iff (!r_rst_n) rt |=> rstat);
endmodule

bind dual_mode_fifo dmf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en(wr_en), .w_gray(w_gray), .wstat(wstat), .half_full(half_full),
  .almost_full(almost_full), .rd_en(rd_en), .rt(rt), .rstat(rstat),
  .dout(dout));

// File: tb/dual_mode_fifo_test.sv
`timescale 1ns/1ps
module dual_mode_fifo_test;
  logic        wclk = 0, rclk = 0;
  logic        mrst_n = 0, prst_n = 1, fwft_sel = 0;
  logic        wr_en = 0, ofs_wr = 0, rd_en = 0, rt = 0;
  logic [35:0] din = '0;
  logic [3:0]  ae_ofs_in = '0, af_ofs_in = '0;
  logic [35:0] dout;
  logic        rstat, wstat, half_full, almost_empty, almost_full;
  int          n_chk = 0, n_bad = 0;

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #5 rclk = ~rclk;
  end

  dual_mode_fifo uut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .wr_en(wr_en), .din(din), .ofs_wr(ofs_wr),
    .ae_ofs_in(ae_ofs_in), .af_ofs_in(af_ofs_in), .rd_en(rd_en), .rt(rt),
    .dout(dout), .rstat(rstat), .wstat(wstat), .half_full(half_full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic master_reset(logic mode);
    mrst_n = 0; fwft_sel = mode; wr_en = 0; rd_en = 0; rt = 0; ofs_wr = 0;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    settle();
  endtask

  task automatic partial_reset();
    prst_n = 0;
    repeat (4) @(negedge wclk);
    prst_n = 1;
    settle();
  endtask

  task automatic wr_words(int n, logic [35:0] base);
    @(negedge wclk);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; din = base + 36'(i);
      @(negedge wclk);
    end
    wr_en = 0;
  endtask

  // standard timing: called at a falling rclk edge
  task automatic rd_std(int n, logic [35:0] base, string req);
    for (int i = 0; i < n; i++) begin
      rd_en = 1;
      @(negedge rclk);
      chk(req, dout, base + 36'(i));
    end
    rd_en = 0;
  endtask

  // look-ahead timing: head checked before it is acknowledged
  task automatic rd_fwft(int n, logic [35:0] base, string req);
    for (int i = 0; i < n; i++) begin
      chk(req, dout, base + 36'(i));
      rd_en = 1;
      @(negedge rclk);
    end
    rd_en = 0;
  endtask

  task automatic replay_pulse();
    @(negedge rclk);
    rt = 1;
    @(negedge rclk);
    rt = 0;
  endtask

  task automatic t_reset_state();
    master_reset(0);
    chk("R1 rstat", rstat, 1);
    chk("R1 wstat", wstat, 0);
    chk("R1 half_full", half_full, 0);
    chk("R1 almost_empty", almost_empty, 1);
    chk("R1 almost_full", almost_full, 0);
    chk("R1 dout", dout, 0);
  endtask

  task automatic t_standard();
    master_reset(0);
    wr_words(3, 36'h100);
    settle();
    chk("R3 not empty", rstat, 0);
    chk("R3 no fall-through", dout, 0);
    chk("R8 above default offset", almost_empty, 0);
    rd_std(3, 36'h100, "R3 order");
    settle();
    chk("R3 empty after drain", rstat, 1);
    chk("R8 drained", almost_empty, 1);
    rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    @(negedge rclk);
    chk("R6 read on empty", dout, 36'h102);
  endtask

  task automatic t_fill();
    master_reset(0);
    wr_words(8, 36'h200);
    settle();
    chk("R7 eight words", half_full, 0);
    wr_words(1, 36'h208);
    settle();
    chk("R7 nine words", half_full, 1);
    wr_words(5, 36'h209);
    settle();
    chk("R9 fourteen words", almost_full, 0);
    wr_words(1, 36'h20E);
    settle();
    chk("R9 fifteen words", almost_full, 1);
    chk("R5 fifteen words", wstat, 0);
    wr_words(1, 36'h20F);
    settle();
    chk("R5 sixteen words", wstat, 1);
    wr_words(1, 36'hBAD);
    settle();
    rd_std(16, 36'h200, "R5 contents");
    settle();
    chk("R5 extra write dropped", rstat, 1);
    chk("R5 last word", dout, 36'h20F);
  endtask

  task automatic t_offsets();
    master_reset(0);
    @(negedge wclk);
    ofs_wr = 1; ae_ofs_in = 4'd3; af_ofs_in = 4'd3;
    @(negedge wclk);
    ofs_wr = 0;
    wr_words(2, 36'h300);
    settle();
    chk("R11 before partial reset", rstat, 0);
    partial_reset();
    chk("R11 emptied", rstat, 1);
    chk("R11 almost_empty", almost_empty, 1);
    chk("R11 wstat", wstat, 0);
    wr_words(3, 36'h310);
    settle();
    chk("R10 three words at offset", almost_empty, 1);
    wr_words(1, 36'h313);
    settle();
    chk("R8 four words", almost_empty, 0);
    wr_words(8, 36'h314);
    settle();
    chk("R10 twelve words", almost_full, 0);
    wr_words(1, 36'h31C);
    settle();
    chk("R10 thirteen words", almost_full, 1);
    chk("R2 standard kept", dout, 0);
    master_reset(0);
    wr_words(2, 36'h320);
    settle();
    chk("R10 default restored", almost_empty, 0);
  endtask

  task automatic t_fwft();
    master_reset(1);
    fwft_sel = 0;
    chk("R1 look-ahead not ready", rstat, 1);
    wr_words(1, 36'h400);
    settle();
    chk("R4 ready", rstat, 0);
    chk("R4 head shown", dout, 36'h400);
    chk("R8 output word counted", almost_empty, 1);
    wr_words(3, 36'h401);
    settle();
    chk("R8 four words", almost_empty, 0);
    rd_fwft(4, 36'h400, "R4 order");
    settle();
    chk("R4 not ready after drain", rstat, 1);
    rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    @(negedge rclk);
    chk("R6 read when not ready", dout, 36'h403);
    partial_reset();
    wr_words(1, 36'h410);
    settle();
    chk("R2 mode kept", dout, 36'h410);
  endtask

  task automatic t_replay_fwft();
    master_reset(1);
    wr_words(4, 36'h500);
    settle();
    rd_fwft(2, 36'h500, "R4 before replay");
    chk("R4 third head", dout, 36'h502);
    replay_pulse();
    chk("R12 setup not ready", rstat, 1);
    settle();
    chk("R12 ready again", rstat, 0);
    rd_fwft(4, 36'h500, "R12 replay order");
  endtask

  task automatic t_replay_std();
    master_reset(0);
    wr_words(3, 36'h600);
    settle();
    rd_std(3, 36'h600, "R3 before replay");
    settle();
    chk("R3 empty", rstat, 1);
    replay_pulse();
    chk("R12 setup flag", rstat, 1);
    settle();
    chk("R12 data available", rstat, 0);
    rd_std(3, 36'h600, "R12 replay order");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_standard();
    t_fill();
    t_offsets();
    t_fwft();
    t_replay_fwft();
    t_replay_std();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule